// File: doc/BRIEF.md
# Frame-Paced Luma Gain Regulator

This block steers the global analog gain of an image sensor towards a mid-grey brightness target. After every finished frame the surrounding logic supplies four averaged colour samples taken from the centre of the picture (two green, one red, one blue) along with the gain the sensor is currently running at. The regulator does not act on every frame. A countdown lets thirteen frames go by, and only on the fourteenth does it form a weighted brightness estimate and decide whether to move the gain.

The brightness estimate is built from shifts and adds only. The two greens are averaged, each channel is scaled by a fixed weight, each product is cut to a byte, and the three terms are summed and saturated to a byte. When the estimate falls outside a band of ±20 around 128, the gain moves by the signed error shifted right by four places, using floor semantics. The result is then held between a ceiling of 31 and a low limit: any result below 4 is forced to 3. A one-cycle strobe marks every new gain value. Fetching the statistics and writing the gain to the sensor belong to the surrounding logic.

Top module: `luma_agc`

## Requirements
- R1: While `agc_en` is low, `upd_valid` never asserts, no matter how many frame strobes arrive, and `gain_out` keeps its value.
- R2: The cycle after `agc_en` is seen high with the countdown idle, the countdown is loaded. The 14th `frame_done` after that load triggers an evaluation, and so does every 14th strobe after it. The other strobes never produce an update.
- R3: The green term uses the floor of (G1 + G2) / 2.
- R4: luma = min(255, ((R·232)>>10) + (B>>3) + ((g·672)>>10)), with each of the three terms kept to 8 bits.
- R5: An evaluation whose luma lies in 108..148 inclusive makes no update.
- R6: An out-of-band evaluation yields gain_in + floor((128 − luma)/16), which rounds towards minus infinity for negative errors.
- R7: A computed gain above 31 is output as 31.
- R8: A computed gain below 4 is output as 3. A computed gain of exactly 4 is output unchanged.
- R9: `upd_valid` is a one-cycle pulse. It rises two clock edges after the edge that samples the triggering `frame_done`, and the statistics and `gain_in` are sampled at that same edge. `gain_out` changes only together with the pulse.
- R10: After reset, `upd_valid` is 0 and `gain_out` is 0.
- R11: Dropping `agc_en` part way through the countdown discards it. When `agc_en` is raised again, the count starts over from the full 14 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe at the end of each frame |
| agc_en | input | 1 | Enables automatic gain regulation |
| stat_g1 | input | 8 | First green centre average |
| stat_r | input | 8 | Red centre average |
| stat_b | input | 8 | Blue centre average |
| stat_g2 | input | 8 | Second green centre average |
| gain_in | input | 8 | Gain currently applied to the sensor |
| upd_valid | output | 1 | New gain strobe |
| gain_out | output | 8 | Regulated gain, valid with `upd_valid` |

## Verification
The bench places directed statistics exactly on the band edges, at luma 107, 108, 148 and 149. A deadband off by one would update at 108 or 148, or stay silent at 107. A luma of 149 gives an error of −21, which tells floor shifting (−2) apart from truncating division (−1). Green pairs of odd sum catch rounding in the green average. Gains that land above 31, below 4 and exactly on 4 test both clamps and their asymmetry. Runs of thirteen frames with out-of-band statistics, both after an update and after re-enabling in the middle of a countdown, expose a counter that is off by one or keeps its stale count: either fault shows up as an early or missing update.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic [STAT_W-1:0] g1;
    logic [STAT_W-1:0] r;
    logic [STAT_W-1:0] b;
    logic [STAT_W-1:0] g2;
  } agc_stats_t;
endpackage

// File: rtl/agc_frame_pacer.sv
module agc_frame_pacer #(
  parameter int RELOAD = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic frame_i,
  output logic fire_o
);
  localparam int CW = $clog2(RELOAD + 1) + 1;
  localparam logic signed [CW-1:0] LOAD_V = CW'(RELOAD);
  localparam logic signed [CW-1:0] IDLE_V = '1;

  logic signed [CW-1:0] cnt_q, cnt_d;
  logic                 cnt_en;
  logic                 fire;

  // next state
  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!en_i) begin
      cnt_d = IDLE_V;
    end else if (cnt_q[CW-1]) begin
      cnt_d = LOAD_V;
    end else if (frame_i) begin
      if (cnt_q == '0) begin
        fire  = 1'b1;
        cnt_d = LOAD_V;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cnt_en = !en_i || cnt_q[CW-1] || frame_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE_V;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fire_o = fire;

  a_r1_no_fire_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fire_o);
  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == IDLE_V));
  a_r2_reload_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == LOAD_V));
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_q[CW-1] |-> (cnt_q <= LOAD_V));
endmodule

// File: rtl/agc_luma_calc.sv
module agc_luma_calc
  import agc_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  agc_stats_t        stats_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              vld_o,
  output logic [STAT_W-1:0] luma_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int PW = STAT_W + 10;

  logic [STAT_W:0]   gsum;
  logic [STAT_W-1:0] gavg;
  logic [PW-1:0]     r_ext, b_ext, g_ext;
  logic [PW-1:0]     r_prod, b_prod, g_prod;
  logic [STAT_W-1:0] rw, bw, gw;
  logic [STAT_W+1:0] lsum;
  logic [STAT_W-1:0] luma_d;

  logic              vld_q;
  logic [STAT_W-1:0] luma_q;
  logic [GAIN_W-1:0] gain_q;

  // green pair average, floor
  assign gsum = {1'b0, stats_i.g1} + {1'b0, stats_i.g2};
  assign gavg = gsum[STAT_W:1];

  assign r_ext = PW'(stats_i.r);
  assign b_ext = PW'(stats_i.b);
  assign g_ext = PW'(gavg);

  // weights 232/1024, 128/1024, 672/1024 from shift-add
  assign r_prod = (r_ext << 8) - (r_ext << 4) - (r_ext << 3);
  assign b_prod = b_ext << 7;
  assign g_prod = (g_ext << 9) + (g_ext << 7) + (g_ext << 5);

  // each term kept to a byte
  assign rw = r_prod[10 +: STAT_W];
  assign bw = b_prod[10 +: STAT_W];
  assign gw = g_prod[10 +: STAT_W];

  always_comb begin
    lsum = {2'b00, rw} + {2'b00, bw} + {2'b00, gw};
    if (lsum[STAT_W+1:STAT_W] != 2'b00) begin
      luma_d = '1;
    end else begin
      luma_d = lsum[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_q <= '0;
      gain_q <= '0;
    end else if (fire_i) begin
      luma_q <= luma_d;
      gain_q <= gain_i;
    end
  end

  assign vld_o  = vld_q;
  assign luma_o = luma_q;
  assign gain_o = gain_q;

  a_r9_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(luma_o) && $stable(gain_o));
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step
  import agc_pkg::*;
#(
  parameter int GAIN_W     = 8,
  parameter int TARGET     = 128,
  parameter int BAND       = 20,
  parameter int SHIFT      = 4,
  parameter int GAIN_MAX   = 31,
  parameter int GAIN_TRIP  = 4,
  parameter int GAIN_FLOOR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [STAT_W-1:0] luma_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              upd_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int DW = STAT_W + 2;
  localparam int AW = ((GAIN_W > DW) ? GAIN_W : DW) + 2;
  localparam logic [STAT_W-1:0]    LO_EDGE = STAT_W'(TARGET - BAND);
  localparam logic [STAT_W-1:0]    HI_EDGE = STAT_W'(TARGET + BAND);
  localparam logic signed [DW-1:0] TGT_S   = DW'(TARGET);
  localparam logic signed [AW-1:0] MAX_S   = AW'(GAIN_MAX);
  localparam logic signed [AW-1:0] TRIP_S  = AW'(GAIN_TRIP);
  localparam logic [GAIN_W-1:0]    MAX_G   = GAIN_W'(GAIN_MAX);
  localparam logic [GAIN_W-1:0]    FLOOR_G = GAIN_W'(GAIN_FLOOR);

  logic signed [DW-1:0] err;
  logic signed [DW-1:0] step;
  logic signed [AW-1:0] sum;
  logic [GAIN_W-1:0]    clamped;
  logic                 out_band;
  logic                 upd_d;
  logic                 upd_q;
  logic [GAIN_W-1:0]    gain_q;

  always_comb begin
    err      = TGT_S - $signed({2'b00, luma_i});
    step     = err >>> SHIFT;
    sum      = $signed({{(AW-GAIN_W){1'b0}}, gain_i})
             + $signed({{(AW-DW){step[DW-1]}}, step});
    out_band = (luma_i < LO_EDGE) || (luma_i > HI_EDGE);
    upd_d    = vld_i && out_band;
    if (sum > MAX_S) begin
      clamped = MAX_G;
    end else if (sum < TRIP_S) begin
      clamped = FLOOR_G;
    end else begin
      clamped = sum[GAIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
    end else if (upd_d) begin
      gain_q <= clamped;
    end
  end

  assign upd_o  = upd_q;
  assign gain_o = gain_q;

  a_r5_deadband_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (luma_i >= LO_EDGE) && (luma_i <= HI_EDGE)) |=> !upd_o);
  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (gain_o <= MAX_G));
  a_r8_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (gain_o >= FLOOR_G));
  a_r9_gain_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_d |=> $stable(gain_o));
endmodule

// File: rtl/luma_agc.sv
module luma_agc
  import agc_pkg::*;
#(
  parameter int GAIN_W     = 8,
  parameter int FRAME_SKIP = 13,
  parameter int TARGET     = 128,
  parameter int BAND       = 20,
  parameter int SHIFT      = 4,
  parameter int GAIN_MAX   = 31,
  parameter int GAIN_TRIP  = 4,
  parameter int GAIN_FLOOR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              agc_en,
  input  logic [STAT_W-1:0] stat_g1,
  input  logic [STAT_W-1:0] stat_r,
  input  logic [STAT_W-1:0] stat_b,
  input  logic [STAT_W-1:0] stat_g2,
  input  logic [GAIN_W-1:0] gain_in,
  output logic              upd_valid,
  output logic [GAIN_W-1:0] gain_out
);
  agc_stats_t        stats;
  logic              fire;
  logic              s1_vld;
  logic [STAT_W-1:0] s1_luma;
  logic [GAIN_W-1:0] s1_gain;

  assign stats = '{g1: stat_g1, r: stat_r, b: stat_b, g2: stat_g2};

  agc_frame_pacer #(
    .RELOAD (FRAME_SKIP)
  ) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (agc_en),
    .frame_i (frame_done),
    .fire_o  (fire)
  );

  agc_luma_calc #(
    .GAIN_W (GAIN_W)
  ) u_luma (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (fire),
    .stats_i (stats),
    .gain_i  (gain_in),
    .vld_o   (s1_vld),
    .luma_o  (s1_luma),
    .gain_o  (s1_gain)
  );

  agc_gain_step #(
    .GAIN_W     (GAIN_W),
    .TARGET     (TARGET),
    .BAND       (BAND),
    .SHIFT      (SHIFT),
    .GAIN_MAX   (GAIN_MAX),
    .GAIN_TRIP  (GAIN_TRIP),
    .GAIN_FLOOR (GAIN_FLOOR)
  ) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (s1_vld),
    .luma_i (s1_luma),
    .gain_i (s1_gain),
    .upd_o  (upd_valid),
    .gain_o (gain_out)
  );

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);
  a_r1_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!agc_en && !$past(agc_en) && !$past(agc_en, 2)) |-> !upd_valid);
endmodule

// File: tb/luma_agc_tb.sv
module luma_agc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       frame_done;
  logic       agc_en;
  logic [7:0] stat_g1, stat_r, stat_b, stat_g2;
  logic [7:0] gain_in;
  logic       upd_valid;
  logic [7:0] gain_out;

  int n_chk  = 0;
  int n_fail = 0;
  int bm_cnt = -1;
  bit bm_en  = 0;
  int last_gain = 0;

  luma_agc u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .agc_en     (agc_en),
    .stat_g1    (stat_g1),
    .stat_r     (stat_r),
    .stat_b     (stat_b),
    .stat_g2    (stat_g2),
    .gain_in    (gain_in),
    .upd_valid  (upd_valid),
    .gain_out   (gain_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_luma(int g1, int r, int b, int g2);
    int g, rw, bw, gw, s;
    g  = (g1 + g2) / 2;
    rw = ((r * 232) / 1024) % 256;
    bw = ((b * 128) / 1024) % 256;
    gw = ((g * 672) / 1024) % 256;
    s  = rw + bw + gw;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int ref_gain(int luma, int gain);
    int d, st, n;
    d = 128 - luma;
    if (d >= 0) st = d / 16;
    else        st = -((-d + 15) / 16);
    n = gain + st;
    if (n > 31)     return 31;
    else if (n < 4) return 3;
    return n;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    agc_en = v;
    bm_en  = v;
    if (!v) bm_cnt = -1;
    @(posedge clk);
    if (v && bm_cnt < 0) bm_cnt = 13;
  endtask

  task automatic frame(int g1, int r, int b, int g2, int gain, string tag);
    bit eval;
    int l, eg;
    bit exp_upd;
    @(negedge clk);
    stat_g1 = 8'(g1); stat_r = 8'(r); stat_b = 8'(b); stat_g2 = 8'(g2);
    gain_in = 8'(gain);
    frame_done = 1'b1;
    eval = bm_en && (bm_cnt == 0);
    if (bm_en) bm_cnt = eval ? 13 : bm_cnt - 1;
    @(posedge clk);
    @(negedge clk);
    frame_done = 1'b0;
    stat_g1 = 8'hxx; stat_r = 8'hxx; stat_b = 8'hxx; stat_g2 = 8'hxx; gain_in = 8'hxx;
    check({tag, " R9 early"}, int'(upd_valid), 0);
    @(posedge clk);
    @(negedge clk);
    l = ref_luma(g1, r, b, g2);
    exp_upd = eval && ((l < 108) || (l > 148));
    check({tag, " upd"}, int'(upd_valid), int'(exp_upd));
    if (exp_upd) begin
      eg = ref_gain(l, gain);
      check({tag, " gain"}, int'(gain_out), eg);
      last_gain = eg;
    end else begin
      check({tag, " R9 hold"}, int'(gain_out), last_gain);
    end
  endtask

  task automatic to_eval();
    while (bm_cnt != 0) frame(192, 0, 0, 192, 17, "R2 neutral");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; frame_done = 1'b0; agc_en = 1'b0;
    stat_g1 = '0; stat_r = '0; stat_b = '0; stat_g2 = '0; gain_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 upd", int'(upd_valid), 0);
    check("R10 gain", int'(gain_out), 0);
    rst_n = 1'b1;

    // R1: disabled, extreme statistics
    for (int i = 0; i < 20; i++) frame(0, 0, 0, 0, 20, "R1");

    set_en(1'b1);
    to_eval(); frame(0, 0, 0, 0, 28, "R7 ceiling");
    to_eval(); frame(255, 255, 255, 255, 10, "R8 force3");
    to_eval(); frame(255, 255, 255, 255, 12, "R8 edge4");
    to_eval(); frame(228, 0, 0, 228, 20, "R6 floor shift");
    to_eval(); frame(227, 0, 0, 227, 20, "R5 edge148");
    to_eval(); frame(165, 0, 0, 165, 20, "R5 edge108");
    to_eval(); frame(165, 0, 0, 164, 20, "R3 green floor");
    to_eval(); frame(0, 255, 0, 0, 10, "R4 red");
    to_eval(); frame(0, 0, 255, 0, 10, "R4 blue");

    // R2: period of 14 with out-of-band stats throughout
    for (int i = 0; i < 28; i++) frame(0, 0, 0, 0, 8, "R2 period");

    // R11: restart after mid-count disable
    for (int i = 0; i < 5; i++) frame(192, 0, 0, 192, 9, "R11 pre");
    set_en(1'b0);
    set_en(1'b1);
    for (int i = 0; i < 14; i++) frame(255, 255, 255, 255, 25, "R11 restart");

    // random mix
    for (int i = 0; i < 700; i++) begin
      if ($urandom_range(0, 59) == 0) begin
        set_en(1'b0);
        if ($urandom_range(0, 1) == 1) frame(0, 0, 0, 0, 5, "R1 rand");
        set_en(1'b1);
      end
      frame($urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 40), "R4 R6 rand");
    end
    finish_run();
  end
endmodule